// File: doc/BRIEF.md
# Overclock Recovery Watchdog

This block guards a system whose clock frequency may have been raised too far. Once armed, it counts down whole seconds from a one-second timebase. The host shows that it is still alive by rewriting the timeout value, which reloads the count. If the count runs out while the watchdog is armed, three things happen. The block pulls an active-low system reset low for a fixed number of reference clock cycles. It steers the frequency-select code sent to the clock synthesizer over to a programmed safe code. It also sets a sticky expiry flag that the host can read.

There are two ways to arm the watchdog. One is a strap input that is captured only while reset is asserted. The other is an enable bit in a register. The timeout is held inside the block as a number of seconds. After reset that number is 16. A clear command drops the expiry flag, which also returns the frequency select to its normal source, and starts a fresh countdown from the programmed timeout.

Top module: `wdt_freq_guard`

## Requirements
- R1: After reset the programmed timeout is 16 seconds. An armed watchdog with no timeout write expires on the 16th tick.
- R2: The watchdog is armed when the strap level captured during reset is 1 or when `cfg_en` is 1. Changing `strap_en` after reset has no effect.
- R3: While armed, each cycle with `sec_tick` high lowers the count by one. The cycle after the count reaches zero, `wd_expired` goes to 1. With timeout N, it goes high one clock edge after the edge that samples the Nth tick.
- R4: A cycle with `tmo_we` high stores `tmo_wdata` as the new timeout and restarts the count from that value.
- R5: `sys_rst_n` is 1 in the idle state. It goes to 0 in the same cycle that `wd_expired` rises and stays at 0 for exactly RST_CYCLES clock cycles. The default is 8.
- R6: `fsel_eff` equals `safe_fsel` while `wd_expired` is 1. Otherwise it equals `hw_fsel`.
- R7: A cycle with `wd_clear` high sets `wd_expired` to 0 and reloads the count with the programmed timeout.
- R8: While the watchdog is not armed, the count is held at the programmed timeout and never expires. When the watchdog is armed again, a full timeout is needed before it expires.
- R9: While armed, writing a timeout of 0 makes `wd_expired` rise one cycle after the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| strap_en | input | 1 | Power-up enable strap |
| cfg_en | input | 1 | Register enable bit |
| sec_tick | input | 1 | One-cycle pulse once per second |
| tmo_we | input | 1 | Timeout register write strobe |
| tmo_wdata | input | 8 | Timeout value in seconds |
| wd_clear | input | 1 | Clear expiry flag and rearm |
| hw_fsel | input | 4 | Normal frequency-select code |
| safe_fsel | input | 4 | Safe frequency-select code |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wd_expired | output | 1 | Sticky expiry status |
| fsel_eff | output | 4 | Frequency-select code in effect |

## Verification
The bench counts ticks itself and checks that expiry lands on exactly the Nth tick, with no expiry one cycle earlier. An off-by-one in the counter would expire a second too early or a second too late. The bench also measures the width of the reset pulse, to catch a pulse that is one cycle short or one cycle long. It toggles the strap after reset, leaves the watchdog disarmed across many ticks, and then re-arms it partway through a count. A design that re-samples the strap, or that keeps counting while disarmed, would then expire early. A zero timeout and a restart partway through a count are also driven, to catch a reload that is ignored or that is applied one cycle late.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int TMO_W  = 8;
  localparam int FSEL_W = 4;

  typedef logic [TMO_W-1:0]  tmo_t;
  typedef logic [FSEL_W-1:0] fsel_t;

  // Next value of the seconds counter: a write wins, then a clear or a
  // disarmed watchdog reload, then a tick counts down until zero.
  function automatic tmo_t tmo_step(input tmo_t cur, input tmo_t reload,
                                    input logic wr, input tmo_t wdata,
                                    input logic clr, input logic active,
                                    input logic tick);
    if (wr)                  return wdata;
    if (clr || !active)      return reload;
    if (tick && cur != '0)   return cur - tmo_t'(1);
    return cur;
  endfunction
endpackage

// File: rtl/wdt_enable_src.sv
module wdt_enable_src (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_en,
  input  logic cfg_en,
  output logic armed
);
  logic strap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_en;
  end

  assign armed = strap_q | cfg_en;

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q)); // R2
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter tmo_t TMO_DEFAULT = tmo_t'(16)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic sec_tick,
  input  logic tmo_we,
  input  tmo_t tmo_wdata,
  input  logic wd_clear,
  output logic expired,
  output logic expire_evt
);
  tmo_t tmo_reg;
  tmo_t cnt;
  logic active;

  assign active     = armed & ~expired;
  assign expire_evt = active & (cnt == '0) & ~tmo_we & ~wd_clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_reg <= TMO_DEFAULT;
      cnt     <= TMO_DEFAULT;
      expired <= 1'b0;
    end else begin
      if (tmo_we) tmo_reg <= tmo_wdata;
      cnt <= tmo_step(cnt, tmo_reg, tmo_we, tmo_wdata, wd_clear, active, sec_tick);
      if (wd_clear)        expired <= 1'b0;
      else if (expire_evt) expired <= 1'b1;
    end
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_we |=> (cnt == $past(tmo_wdata)) && (tmo_reg == $past(tmo_wdata))); // R4
  AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sec_tick && cnt != '0 && !tmo_we && !wd_clear) |=> (cnt == $past(cnt) - tmo_t'(1))); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !tmo_we) |=> (cnt == tmo_reg) && !$rose(expired)); // R8
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> expired); // R3
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear |=> !expired && (cnt == tmo_reg)); // R7
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_o_n
);
  localparam int PW = $clog2(RST_CYCLES + 1);
  localparam logic [PW-1:0] LOAD = PW'(RST_CYCLES);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            pcnt <= '0;
    else if (fire)         pcnt <= LOAD;
    else if (pcnt != '0)   pcnt <= pcnt - PW'(1);
  end

  assign rst_o_n = (pcnt == '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !rst_o_n); // R5
  AST_PULSE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && pcnt != '0) |=> (pcnt == $past(pcnt) - PW'(1))); // R5
endmodule

// File: rtl/wdt_freq_guard.sv
module wdt_freq_guard
  import wdt_pkg::*;
#(
  parameter int   RST_CYCLES  = 8,
  parameter tmo_t TMO_DEFAULT = tmo_t'(16)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_en,
  input  logic              cfg_en,
  input  logic              sec_tick,
  input  logic              tmo_we,
  input  logic [TMO_W-1:0]  tmo_wdata,
  input  logic              wd_clear,
  input  logic [FSEL_W-1:0] hw_fsel,
  input  logic [FSEL_W-1:0] safe_fsel,
  output logic              sys_rst_n,
  output logic              wd_expired,
  output logic [FSEL_W-1:0] fsel_eff
);
  logic armed;
  logic expire_evt;

  wdt_enable_src u_en (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .cfg_en(cfg_en), .armed(armed)
  );

  wdt_countdown #(.TMO_DEFAULT(TMO_DEFAULT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .armed(armed), .sec_tick(sec_tick),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .wd_clear(wd_clear),
    .expired(wd_expired), .expire_evt(expire_evt)
  );

  wdt_rst_stretch #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(expire_evt), .rst_o_n(sys_rst_n)
  );

  assign fsel_eff = wd_expired ? safe_fsel : hw_fsel;

  AST_SAFE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |-> (fsel_eff == safe_fsel)); // R6
  AST_RESET_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_expired) |-> !sys_rst_n); // R5
endmodule

// File: tb/tb_wdt_freq_guard.sv
module tb_wdt_freq_guard;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC = 8;

  logic clk = 1'b0;
  logic rst_n, strap_en, cfg_en, sec_tick, tmo_we, wd_clear;
  logic [7:0] tmo_wdata;
  logic [3:0] hw_fsel, safe_fsel, fsel_eff;
  logic sys_rst_n, wd_expired;
  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_freq_guard #(.RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .cfg_en(cfg_en),
    .sec_tick(sec_tick), .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
    .wd_clear(wd_clear), .hw_fsel(hw_fsel), .safe_fsel(safe_fsel),
    .sys_rst_n(sys_rst_n), .wd_expired(wd_expired), .fsel_eff(fsel_eff)
  );

  function automatic logic [3:0] exp_fsel(input logic exp_flag);
    return exp_flag ? safe_fsel : hw_fsel;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; strap_en = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick_once(input bit gap);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    if (gap) repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic write_tmo(input int v);
    tmo_we = 1'b1; tmo_wdata = 8'(v);
    @(negedge clk);
    tmo_we = 1'b0;
  endtask

  task automatic clear_wd();
    wd_clear = 1'b1;
    @(negedge clk);
    wd_clear = 1'b0;
    chk("R7 flag cleared", int'(wd_expired), 0);
    chk("R6 normal select after clear", int'(fsel_eff), int'(hw_fsel));
  endtask

  // Wait out the reset pulse starting at its first low sample; check width.
  task automatic measure_pulse();
    int low = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (!sys_rst_n) low++;
      else break;
    end
    chk("R5 pulse width", low, RSTC);
  endtask

  task automatic expect_expiry(input int n, input string req);
    for (int i = 0; i < n - 1; i++) tick_once(1'b1);
    chk({req, " no early expiry"}, int'(wd_expired), 0);
    tick_once(1'b0);
    chk({req, " count at zero, flag not yet set"}, int'(wd_expired), 0);
    @(negedge clk);
    chk({req, " expiry on last tick"}, int'(wd_expired), 1);
    chk("R5 reset low with expiry", int'(sys_rst_n), 0);
    chk("R6 safe select", int'(fsel_eff), int'(exp_fsel(1'b1)));
    measure_pulse();
    chk("R6 safe held after pulse", int'(fsel_eff), int'(safe_fsel));
    chk("R3 flag sticky", int'(wd_expired), 1);
    clear_wd();
    chk("R5 reset released", int'(sys_rst_n), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    cfg_en = 1'b0; sec_tick = 1'b0; tmo_we = 1'b0; tmo_wdata = '0;
    wd_clear = 1'b0; hw_fsel = 4'h5; safe_fsel = 4'hA;

    do_reset(1'b1);
    chk("R5 idle reset high", int'(sys_rst_n), 1);
    chk("R3 idle flag low", int'(wd_expired), 0);
    chk("R6 normal select", int'(fsel_eff), 5);

    strap_en = 1'b0;
    expect_expiry(16, "R1 R2 default timeout via strap");
    expect_expiry(16, "R7 rearm after clear");

    do_reset(1'b0);
    for (int i = 0; i < 40; i++) begin
      hw_fsel = 4'($urandom);
      tick_once(1'b1);
      chk("R8 disarmed never expires", int'(wd_expired), 0);
      chk("R6 follows hw select", int'(fsel_eff), int'(hw_fsel));
    end
    chk("R8 no reset while disarmed", int'(sys_rst_n), 1);
    cfg_en = 1'b1;
    expect_expiry(16, "R8 R2 full timeout after arming by register");

    for (int k = 0; k < 6; k++) begin
      int n;
      n = 1 + int'($urandom % 20);
      hw_fsel = 4'($urandom); safe_fsel = 4'($urandom);
      write_tmo(n);
      expect_expiry(n, "R4 written timeout");
    end

    write_tmo(10);
    for (int i = 0; i < 6; i++) tick_once(1'b1);
    write_tmo(5);
    expect_expiry(5, "R4 restart mid count");

    write_tmo(0);
    chk("R9 not yet expired at write", int'(wd_expired), 0);
    @(negedge clk);
    chk("R9 zero timeout expires", int'(wd_expired), 1);
    chk("R9 reset low", int'(sys_rst_n), 0);
    measure_pulse();
    write_tmo(12);
    clear_wd();

    for (int i = 0; i < 8; i++) tick_once(1'b1);
    cfg_en = 1'b0;
    @(negedge clk);
    cfg_en = 1'b1;
    expect_expiry(12, "R8 reload after disarm");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule